// File: doc/BRIEF.md
# Serial Clock Divider Search Engine

This block picks the settings of a two-stage serial clock divider. Give it the frequency of the clock that feeds the divider and the serial clock rate wanted. It then searches for an even prescaler and an 8-bit post-divider whose combined division gives the fastest rate that does not exceed the wanted rate. The first stage divides by an even value from 2 to 254. The second stage divides by its register value plus one. The engine returns both register values and the rate that the pair actually achieves.

The search tests one candidate per clock cycle. For each prescaler it sweeps the whole post-divider range before it moves the prescaler up by 2. The engine never divides inside the loop. It decides whether a candidate fits by comparing the input frequency against a running product of the target and the division, and that product grows by one addition per step. When the search stops, a 32-cycle restoring divider computes the achieved rate once. A pulse on the start input begins a search, and a one-cycle done pulse ends it. The result outputs hold their values until the next search completes.

Top module: `spi_div_finder`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `error_o` are 0, and `prescale_o`, `postdiv_o` and `rate_o` are 0.
- R2: Candidates are visited in this order: prescaler 2, 4, ..., 254, and for each prescaler the post-divider field 0, 1, ..., 255. The result is the first candidate for which floor(clk_hz / ((postdiv + 1) * prescale)) <= target_hz.
- R3: `rate_o` equals floor(floor(clk_hz / prescale) / (postdiv + 1)) for the reported pair, as a 32-bit value.
- R4: On a successful search, `prescale_o` is even and lies in 2..254, and `postdiv_o` is in 0..255.
- R5: If no candidate fits, `error_o` is 1, `prescale_o` is 254, `postdiv_o` is 255, and `rate_o` follows R3 for that pair.
- R6: A start with `target_hz_i` equal to 0 is rejected. `done_o` and `error_o` are 1 on the clock edge after the start, `prescale_o`, `postdiv_o` and `rate_o` are 0, and `busy_o` stays 0.
- R7: A start pulse while `busy_o` is 1 is ignored. The search in progress finishes with the result for its own inputs.
- R8: `done_o` is high for exactly one cycle per accepted start. `busy_o` is 1 from the edge after an accepted nonzero start until `done_o` rises. The result outputs change only on the edge where `done_o` rises.
- R9: On a successful search, `rate_o` is less than or equal to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a search (used only while idle) |
| clk_hz_i | input | 32 | Frequency of the clock feeding the divider, in Hz |
| target_hz_i | input | 32 | Highest allowed serial clock rate, in Hz |
| busy_o | output | 1 | A search or rate division is in progress |
| done_o | output | 1 | One-cycle pulse: results are valid |
| error_o | output | 1 | Target was zero or no candidate fits |
| prescale_o | output | 8 | Even prescaler value found |
| postdiv_o | output | 8 | Post-divider register value found |
| rate_o | output | 32 | Achieved serial clock rate, in Hz |

## Verification
The assertions assume that the inputs are sampled only when a start is accepted. They also assume that the divisor handed to the rate divider is never zero, which holds because every reachable prescaler is at least 2. The incremental-product checks assume the target fits in 32 bits, so that target plus one fits the widened product. The bench keeps to these assumptions: it changes the inputs only together with a start pulse, and it sends its one start-while-busy pulse during a search whose own inputs stay valid. The sweeps use ratios of clock to target that keep most searches to a few hundred cycles, plus one search that runs the full range to saturation.

// File: rtl/spi_div_pkg.sv
// Package: shared types for the serial clock divider search engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package spi_div_pkg;

    // Top-level sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DIVIDE = 2'd2
    } finder_state_t;

endpackage

// File: rtl/spi_div_search.sv
// Module: spi_div_search
// Walks divider candidates one per cycle. The inner post-divider sweeps
// fully before the even prescaler steps up by 2. A candidate fits when
// clk < (target + 1) * den, which equals floor(clk / den) <= target.
// The product is kept incrementally, so no multiplier or divider sits in
// the loop. Assumes load_i is a single-cycle pulse with target_i != 0.
module spi_div_search #(
    parameter int FREQ_W = 32,
    parameter int PRE_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [FREQ_W-1:0]        clk_hz_i,
    input  logic [FREQ_W-1:0]        target_i,
    output logic                     found_o,
    output logic                     sat_o,
    output logic [PRE_W-1:0]         pre_o,
    output logic [DIV_W-1:0]         div_o,
    output logic [PRE_W+DIV_W-1:0]   den_o
);
    localparam int PROD_W = FREQ_W + 1 + PRE_W + DIV_W;
    localparam int DEN_W  = PRE_W + DIV_W;
    localparam logic [PRE_W-1:0] PRE_MAX = {{(PRE_W-1){1'b1}}, 1'b0};
    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

    logic              active_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DIV_W-1:0]  div_q;
    logic [DEN_W-1:0]  den_q;
    logic [PROD_W-1:0] step_q;   // (target + 1) * prescale
    logic [PROD_W-1:0] tstep_q;  // 2 * (target + 1)
    logic [PROD_W-1:0] prod_q;   // (target + 1) * den
    logic [FREQ_W-1:0] clk_hz_q;
    logic              found_q;
    logic              sat_q;

    logic [PROD_W-1:0] seed_step;
    logic [PROD_W-1:0] clk_ext;
    logic              fits;

    // Seed step and comparison against the current candidate.
    always_comb begin
        seed_step = ({{(PROD_W-FREQ_W){1'b0}}, target_i} + PROD_W'(1)) << 1;
        clk_ext   = {{(PROD_W-FREQ_W){1'b0}}, clk_hz_q};
        fits      = (clk_ext < prod_q);
    end

    // Candidate stepping: one candidate tested per active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pre_q    <= '0;
            div_q    <= '0;
            den_q    <= '0;
            step_q   <= '0;
            tstep_q  <= '0;
            prod_q   <= '0;
            clk_hz_q <= '0;
            found_q  <= 1'b0;
            sat_q    <= 1'b0;
        end else begin
            found_q <= 1'b0;
            if (load_i) begin
                active_q <= 1'b1;
                pre_q    <= PRE_W'(2);
                div_q    <= '0;
                den_q    <= DEN_W'(2);
                step_q   <= seed_step;
                tstep_q  <= seed_step;
                prod_q   <= seed_step;
                clk_hz_q <= clk_hz_i;
                sat_q    <= 1'b0;
            end else if (active_q) begin
                if (fits) begin
                    found_q  <= 1'b1;
                    active_q <= 1'b0;
                end else if (div_q == DIV_MAX) begin
                    if (pre_q == PRE_MAX) begin
                        found_q  <= 1'b1;
                        sat_q    <= 1'b1;
                        active_q <= 1'b0;
                    end else begin
                        pre_q  <= pre_q + PRE_W'(2);
                        div_q  <= '0;
                        step_q <= step_q + tstep_q;
                        prod_q <= step_q + tstep_q;
                        den_q  <= DEN_W'(pre_q) + DEN_W'(2);
                    end
                end else begin
                    div_q  <= div_q + DIV_W'(1);
                    prod_q <= prod_q + step_q;
                    den_q  <= den_q + DEN_W'(pre_q);
                end
            end
        end
    end

    assign found_o = found_q;
    assign sat_o   = sat_q;
    assign pre_o   = pre_q;
    assign div_o   = div_q;
    assign den_o   = den_q;

    // R4: a reported prescaler is even and at least 2.
    p_found_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (pre_o >= PRE_W'(2)) && !pre_o[0]);

    // R3: the running divisor tracks prescale * (postdiv + 1).
    p_den_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (32'(den_q) == 32'(pre_q) * (32'(div_q) + 32'd1)));

    // R2: the running product tracks (target + 1) * divisor.
    p_prod_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (64'(prod_q) * 64'd2 == 64'(tstep_q) * 64'(den_q)));

    // R5: saturation is flagged only at the last candidate.
    p_sat_corner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && sat_o) |-> (pre_o == PRE_MAX) && (div_o == DIV_MAX));
endmodule

// File: rtl/spi_div_longdiv.sv
// Module: spi_div_longdiv
// Restoring shift-subtract divider: one quotient bit per cycle, NUM_W
// cycles per division. Assumes den_i != 0 when load_i is pulsed.
module spi_div_longdiv #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic             take;

    // Partial remainder with the next numerator bit shifted in.
    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        take  = (trial >= {1'b0, den_q});
    end

    // Iteration: one quotient bit resolved per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q    <= '0;
            rem_q    <= '0;
            den_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                quo_q    <= num_i;
                rem_q    <= '0;
                den_q    <= den_i;
                cnt_q    <= CNT_W'(NUM_W);
                active_q <= 1'b1;
            end else if (active_q) begin
                rem_q <= take ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
                quo_q <= {quo_q[NUM_W-2:0], take};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;

    // R3: the divider is never started with a zero divisor.
    p_den_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (den_i != '0));

    // R3: the final remainder is below the divisor.
    p_rem_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_q < den_q));
endmodule

// File: rtl/spi_div_finder.sv
// Module: spi_div_finder (top)
// Sequences the candidate search and the final rate division, and owns
// the result registers and the start/done handshake. Assumes start_i is
// sampled only in idle; inputs are captured on an accepted start.
module spi_div_finder
    import spi_div_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int PRE_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] clk_hz_i,
    input  logic [FREQ_W-1:0] target_hz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic [PRE_W-1:0]  prescale_o,
    output logic [DIV_W-1:0]  postdiv_o,
    output logic [FREQ_W-1:0] rate_o
);
    localparam int DEN_W = PRE_W + DIV_W;
    localparam logic [PRE_W-1:0] PRE_MAX = {{(PRE_W-1){1'b1}}, 1'b0};
    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

    finder_state_t     state_q;
    logic [FREQ_W-1:0] clk_hz_q;
    logic [FREQ_W-1:0] target_q;
    logic              done_q;
    logic              err_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DIV_W-1:0]  div_q;
    logic [FREQ_W-1:0] rate_q;

    logic              accept;
    logic              search_load;
    logic              s_found;
    logic              s_sat;
    logic [PRE_W-1:0]  s_pre;
    logic [DIV_W-1:0]  s_div;
    logic [DEN_W-1:0]  s_den;
    logic              div_load;
    logic              d_done;
    logic [FREQ_W-1:0] d_quo;

    // Handshake decode: accepted starts and sub-block launches.
    always_comb begin
        accept      = start_i && (state_q == ST_IDLE);
        search_load = accept && (target_hz_i != '0);
        div_load    = (state_q == ST_SEARCH) && s_found;
    end

    spi_div_search #(
        .FREQ_W(FREQ_W),
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (search_load),
        .clk_hz_i(clk_hz_i),
        .target_i(target_hz_i),
        .found_o (s_found),
        .sat_o   (s_sat),
        .pre_o   (s_pre),
        .div_o   (s_div),
        .den_o   (s_den)
    );

    spi_div_longdiv #(
        .NUM_W(FREQ_W),
        .DEN_W(DEN_W)
    ) u_rate_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(div_load),
        .num_i (clk_hz_q),
        .den_i (s_den),
        .done_o(d_done),
        .quo_o (d_quo)
    );

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            clk_hz_q <= '0;
            target_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            pre_q    <= '0;
            div_q    <= '0;
            rate_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (target_hz_i == '0) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            pre_q  <= '0;
                            div_q  <= '0;
                            rate_q <= '0;
                        end else begin
                            clk_hz_q <= clk_hz_i;
                            target_q <= target_hz_i;
                            state_q  <= ST_SEARCH;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (s_found) begin
                        state_q <= ST_DIVIDE;
                    end
                end
                ST_DIVIDE: begin
                    if (d_done) begin
                        done_q  <= 1'b1;
                        err_q   <= s_sat;
                        pre_q   <= s_pre;
                        div_q   <= s_div;
                        rate_q  <= d_quo;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign error_o    = err_q;
    assign prescale_o = pre_q;
    assign postdiv_o  = div_q;
    assign rate_o     = rate_q;

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: results hold between completions.
    p_outs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(prescale_o) && $stable(postdiv_o)
                    && $stable(rate_o) && $stable(error_o));

    // R6: a zero target is rejected on the next edge.
    p_zero_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && target_hz_i == '0) |=> done_o && error_o && !busy_o);

    // R9: a successful rate never exceeds the captured target.
    p_rate_le_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> (rate_o <= target_q));

    // R5: a nonzero error result sits at the last candidate.
    p_sat_values_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && error_o && prescale_o != '0) |-> (prescale_o == PRE_MAX) && (postdiv_o == DIV_MAX));

    // R7: a start while busy does not disturb the captured target.
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(target_q));
endmodule

// File: tb/spi_div_finder_tb.sv
`timescale 1ns/1ps
module spi_div_finder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] clk_hz_i = '0;
    logic [31:0] target_hz_i = '0;
    logic        busy_o, done_o, error_o;
    logic [7:0]  prescale_o, postdiv_o;
    logic [31:0] rate_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_div_finder u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .clk_hz_i(clk_hz_i), .target_hz_i(target_hz_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .prescale_o(prescale_o), .postdiv_o(postdiv_o), .rate_o(rate_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference search computed by division, in the stated visit order.
    task automatic ref_search(input longint c, input longint t,
                              output longint pre, output longint dv,
                              output longint rate, output bit err);
        bit hit = 1'b0;
        err = 1'b0; pre = 254; dv = 255;
        for (longint p = 2; p <= 254 && !hit; p += 2) begin
            for (longint d = 0; d <= 255 && !hit; d++) begin
                if (c / ((d + 1) * p) <= t) begin
                    hit = 1'b1; pre = p; dv = d;
                end
            end
        end
        if (!hit) err = 1'b1;
        rate = (c / pre) / (dv + 1);
    endtask

    task automatic run_case(input longint c, input longint t);
        longint ep, ed, er;
        bit ee;
        @(negedge clk);
        clk_hz_i = 32'(c); target_hz_i = 32'(t); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy after start", longint'(busy_o), 1);
        while (!done_o) @(negedge clk);
        ref_search(c, t, ep, ed, er, ee);
        check("R2 prescale", longint'(prescale_o), ep);
        check("R2 postdiv", longint'(postdiv_o), ed);
        check("R3 rate", longint'(rate_o), er);
        check(ee ? "R5 error set" : "R4 error clear", longint'(error_o), longint'(ee));
        if (!ee) begin
            check("R4 prescale even", longint'(prescale_o[0]), 0);
            check("R9 rate le target", longint'(longint'(rate_o) <= t), 1);
        end
        @(negedge clk);
        check("R8 done one cycle", longint'(done_o), 0);
        check("R8 idle after done", longint'(busy_o), 0);
    endtask

    initial begin
        longint clks[4] = '{1000000, 48000000, 12345678, 99999};
        longint ratios[12] = '{1, 2, 3, 5, 7, 100, 511, 512, 513, 600, 1000, 1500};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", longint'(busy_o), 0);
        check("R1 done", longint'(done_o), 0);
        check("R1 error", longint'(error_o), 0);
        check("R1 prescale", longint'(prescale_o), 0);
        check("R1 postdiv", longint'(postdiv_o), 0);
        check("R1 rate", longint'(rate_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4/R9: sweep of clocks and ratios, including prescaler wrap.
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 12; j++) begin
                longint t = clks[i] / ratios[j];
                if (t > 0) run_case(clks[i], t);
                if (t > 1) run_case(clks[i], t - 1);
            end
        end
        run_case(1000, 5000);        // target above clock

        // R6: zero target rejected
        @(negedge clk);
        clk_hz_i = 32'd1000000; target_hz_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 done", longint'(done_o), 1);
        check("R6 error", longint'(error_o), 1);
        check("R6 busy", longint'(busy_o), 0);
        check("R6 prescale", longint'(prescale_o), 0);
        check("R6 postdiv", longint'(postdiv_o), 0);
        check("R6 rate", longint'(rate_o), 0);
        @(negedge clk);
        check("R8 done one cycle zero", longint'(done_o), 0);

        // R7: start while busy ignored
        @(negedge clk);
        clk_hz_i = 32'd1000000; target_hz_i = 32'd1666; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        clk_hz_i = 32'd1000000; target_hz_i = 32'd500000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 outputs held while busy", longint'(prescale_o), 0);
        while (!done_o) @(negedge clk);
        check("R7 prescale", longint'(prescale_o), 4);
        check("R7 postdiv", longint'(postdiv_o), 149);
        check("R7 rate", longint'(rate_o), 1666);
        @(negedge clk);

        // R5: saturation when nothing fits
        run_case(100000000, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule